// File: doc/BRIEF.md
# Serial Block Check Character Calculator

A bus-mapped peripheral that accumulates a block check character over data words written by a host. One serial engine covers five check codes: three cyclic redundancy checks (12-bit, 16-bit with reflected 0xA001, CCITT with reflected 0x8408) and two longitudinal parity sums (8-bit and 16-bit). The host selects the code and a double-byte flag in a control/status word. It then writes data words. The engine consumes the data word LSB first, one bit per clock, or one bit per single-step command.

The host sees three word locations on a 16-bit bus with per-byte write enables. Word 0 is control/status (read/write), word 1 is the accumulated result (read-only), and word 2 is the data input (write-only; it reads as zero). Reads are combinational from the word address. A bus write cycle takes priority over shifting, so no shift happens in a cycle that carries a write.

Top module: `bcc_calc`

## Requirements
- R1: After reset the control/status word reads 0x0080 (DONE set, all else zero) and the result word reads 0x0000.
- R2: Control/status layout: mode in [2:0], double-byte in 3, clear command in 4, step command in 5, shift-enable in 6, DONE in 7, quotient in 8. Bits 4, 5 and 15:9 always read 0. DONE and quotient cannot be written.
- R3: A write with byte enable 0 updates bits [7:0] and byte enable 1 updates bits [15:8] of the data word. A write to the high byte of control/status has no effect.
- R4: Bits per data word: mode 0 gives 6. Modes 1, 2, 3 and 5 give 8. Each count doubles when double-byte is 1. Modes 4, 6 and 7 give 0: DONE returns one clock after the data write, and no shift occurs.
- R5: In each shift the feedback is result[0] XOR data[0]. For mode 1 and mode 5 the result becomes (result >> 1), XOR 0xA001 (mode 1) or 0x8408 (mode 5) when the feedback is 1.
- R6: Mode 0 keeps a 12-bit value v. Each shift sets v to (v >> 1), XOR 0xF01 when the feedback is 1. The result reads as v[5:0] in bits [5:0] and v[11:6] in bits [13:8], with other bits zero.
- R7: Mode 2 rotates result[7:0] right, inserting the feedback at bit 7, and leaves [15:8] unchanged. Mode 3 rotates all 16 bits right, inserting the feedback at bit 15.
- R8: A data write clears DONE and zeroes the bit counter. While shift-enable is 1, one shift occurs on every non-write clock until the bit count is reached. The data word shifts right by one on each shift.
- R9: A control/status write with step 1 and shift-enable 0 causes exactly one shift on the next clock, provided DONE is 0 and the count is not reached.
- R10: A control/status write with clear 1 zeroes the result and the counter. A write that changes bits [3:0] zeroes the counter.
- R11: DONE is set on the shift that brings the counter to the bit count. No further shift changes the result until new data is written.
- R12: Writes to the result word leave every register unchanged.
- R13: The quotient bit holds the feedback of the most recent shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe for this cycle |
| addr_i | input | 2 | Word address (0 control/status, 1 result, 2 data) |
| be_i | input | 2 | Byte write enables (0 low byte, 1 high byte) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |

## Verification
The bench builds the block with its default polynomial parameters: 0xA001, 0x8408 and 0xF01 (12-bit). This puts each mode's exact bit-serial result within reach of an independent integer model, with and without the double-byte flag. Comparing every clock exposes timing errors that an end-of-word check would miss: an off-by-one final pulse, a shift in a write cycle, a repeated single step, or a clear that leaves the counter running.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int DW    = 16;
  localparam int CNT_W = 5;

  localparam logic [2:0] MODE_CRC12 = 3'd0;
  localparam logic [2:0] MODE_CRC16 = 3'd1;
  localparam logic [2:0] MODE_LRC8  = 3'd2;
  localparam logic [2:0] MODE_LRC16 = 3'd3;
  localparam logic [2:0] MODE_CCITT = 3'd5;

  typedef struct packed {
    logic       sen;
    logic       ddb;
    logic [2:0] mode;
  } ctl_t;

  function automatic logic [CNT_W-1:0] bit_target(input logic [2:0] m, input logic dbl);
    logic [CNT_W-1:0] base;
    case (m)
      MODE_CRC12:                                base = CNT_W'(6);
      MODE_CRC16, MODE_LRC8, MODE_LRC16, MODE_CCITT: base = CNT_W'(8);
      default:                                   base = '0;
    endcase
    return dbl ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/bcc_host_if.sv
module bcc_host_if
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              be_lo_i,
  input  logic [6:0]        wdata_i,
  input  logic [DW-1:0]     bcc_i,
  input  logic              done_i,
  input  logic              quo_i,
  output ctl_t              ctl_o,
  output logic              wr_any_o,
  output logic              clr_o,
  output logic              setup_chg_o,
  output logic              step_req_o,
  output logic              dr_wr_o,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_RES = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_DAT = ADDR_W'(2);

  ctl_t ctl_q;
  logic ctl_lo_wr;

  assign ctl_lo_wr   = we_i && (addr_i == OFS_CTL) && be_lo_i;
  assign wr_any_o    = we_i;
  assign dr_wr_o     = we_i && (addr_i == OFS_DAT);
  assign clr_o       = ctl_lo_wr && wdata_i[4];
  assign setup_chg_o = ctl_lo_wr && (wdata_i[3:0] != {ctl_q.ddb, ctl_q.mode});
  assign step_req_o  = ctl_lo_wr && wdata_i[5] && !wdata_i[6];
  assign ctl_o       = ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (ctl_lo_wr) ctl_q <= '{sen: wdata_i[6], ddb: wdata_i[3], mode: wdata_i[2:0]};
  end

  logic [DW-1:0] res_view;
  always_comb begin
    if (ctl_q.mode == MODE_CRC12) res_view = {2'b00, bcc_i[11:6], 2'b00, bcc_i[5:0]};
    else                          res_view = bcc_i;
  end

  always_comb begin
    case (addr_i)
      OFS_CTL: rdata_o = {7'd0, quo_i, done_i, ctl_q.sen, 2'b00, ctl_q.ddb, ctl_q.mode};
      OFS_RES: rdata_o = res_view;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bcc_engine.sv
module bcc_engine
  import bcc_pkg::*;
#(
  parameter logic [15:0] CRC16_POLY = 16'hA001,
  parameter logic [15:0] CCITT_POLY = 16'h8408,
  parameter logic [11:0] CRC12_POLY = 12'hF01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctl_t          ctl_i,
  input  logic          wr_any_i,
  input  logic          clr_i,
  input  logic          setup_chg_i,
  input  logic          step_req_i,
  input  logic          dr_wr_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] bcc_o,
  output logic          done_o,
  output logic          quo_o
);
  logic [DW-1:0]    bcc_q, dr_q, bcc_nx, dr_merge;
  logic [CNT_W-1:0] cnt_q, cnt_nx, tgt;
  logic             done_q, quo_q, step_pend_q;
  logic             fb, shift_go;

  assign tgt      = bit_target(ctl_i.mode, ctl_i.ddb);
  assign fb       = bcc_q[0] ^ dr_q[0];
  assign cnt_nx   = cnt_q + CNT_W'(1);
  assign shift_go = !wr_any_i && !done_q && (cnt_q < tgt) && (ctl_i.sen || step_pend_q);

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign dr_merge[b*8 +: 8] = be_i[b] ? wdata_i[b*8 +: 8] : dr_q[b*8 +: 8];
  end

  always_comb begin
    case (ctl_i.mode)
      MODE_CRC12: bcc_nx = {4'd0, (bcc_q[11:0] >> 1) ^ (fb ? CRC12_POLY : 12'd0)};
      MODE_CRC16: bcc_nx = (bcc_q >> 1) ^ (fb ? CRC16_POLY : 16'd0);
      MODE_CCITT: bcc_nx = (bcc_q >> 1) ^ (fb ? CCITT_POLY : 16'd0);
      MODE_LRC8:  bcc_nx = {bcc_q[15:8], fb, bcc_q[7:1]};
      MODE_LRC16: bcc_nx = {fb, bcc_q[15:1]};
      default:    bcc_nx = bcc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcc_q <= '0; dr_q <= '0; cnt_q <= '0;
      done_q <= 1'b1; quo_q <= 1'b0; step_pend_q <= 1'b0;
    end else if (wr_any_i) begin
      step_pend_q <= step_req_i;
      if (clr_i) begin
        bcc_q <= '0;
        cnt_q <= '0;
      end
      if (setup_chg_i) cnt_q <= '0;
      if (dr_wr_i) begin
        dr_q   <= dr_merge;
        done_q <= 1'b0;
        cnt_q  <= '0;
      end
    end else begin
      step_pend_q <= 1'b0;
      if (shift_go) begin
        bcc_q <= bcc_nx;
        dr_q  <= dr_q >> 1;
        quo_q <= fb;
        cnt_q <= cnt_nx;
        if (cnt_nx >= tgt) done_q <= 1'b1;
      end else if (!done_q && cnt_q >= tgt) begin
        done_q <= 1'b1;
      end
    end
  end

  assign bcc_o  = bcc_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  assert_cnt_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= tgt);
  assert_done_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !wr_any_i) |=> ($stable(bcc_q) && $stable(dr_q)));
  assert_load_clears_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_wr_i |=> (!done_q && cnt_q == '0));
  assert_single_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_go && !ctl_i.sen) |=> !shift_go);
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bcc_q == '0 && cnt_q == '0));
endmodule

// File: rtl/bcc_calc.sv
module bcc_calc
  import bcc_pkg::*;
#(
  parameter int          ADDR_W     = 2,
  parameter logic [15:0] CRC16_POLY = 16'hA001,
  parameter logic [15:0] CCITT_POLY = 16'h8408,
  parameter logic [11:0] CRC12_POLY = 12'hF01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o
);
  ctl_t          ctl;
  logic          wr_any, clr, setup_chg, step_req, dr_wr, done, quo;
  logic [DW-1:0] bcc;

  bcc_host_if #(.ADDR_W(ADDR_W)) u_host_if (
    .clk_i, .rst_ni, .we_i, .addr_i,
    .be_lo_i     (be_i[0]),
    .wdata_i     (wdata_i[6:0]),
    .bcc_i       (bcc),
    .done_i      (done),
    .quo_i       (quo),
    .ctl_o       (ctl),
    .wr_any_o    (wr_any),
    .clr_o       (clr),
    .setup_chg_o (setup_chg),
    .step_req_o  (step_req),
    .dr_wr_o     (dr_wr),
    .rdata_o
  );

  bcc_engine #(
    .CRC16_POLY(CRC16_POLY), .CCITT_POLY(CCITT_POLY), .CRC12_POLY(CRC12_POLY)
  ) u_engine (
    .clk_i, .rst_ni,
    .ctl_i       (ctl),
    .wr_any_i    (wr_any),
    .clr_i       (clr),
    .setup_chg_i (setup_chg),
    .step_req_i  (step_req),
    .dr_wr_i     (dr_wr),
    .be_i,
    .wdata_i,
    .bcc_o       (bcc),
    .done_o      (done),
    .quo_o       (quo)
  );
endmodule

// File: tb/bcc_calc_bench.sv
module bcc_calc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [1:0]  be_i = 2'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;

  bcc_calc u_bcc_calc (.*);

  always #10 clk_i = ~clk_i;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural model state
  int m_mode = 0, m_ddb = 0, m_sen = 0, m_done = 1, m_quo = 0, m_cnt = 0, m_step = 0;
  int m_bcc = 0, m_dr = 0;

  function automatic int bits_for(int mode, int ddb);
    int n;
    if (mode == 0) n = 6;
    else if (mode == 1 || mode == 2 || mode == 3 || mode == 5) n = 8;
    else n = 0;
    return ddb ? 2 * n : n;
  endfunction

  function automatic int view_result();
    if (m_mode == 0) return (m_bcc & 'h3F) | (((m_bcc >> 6) & 'h3F) << 8);
    return m_bcc & 'hFFFF;
  endfunction

  task automatic model_step(int we, int a, int be, int d);
    int f, v, n;
    n = bits_for(m_mode, m_ddb);
    if (we) begin
      m_step = 0;
      if (a == 0 && (be & 1)) begin
        if ((d & 'hF) != (m_mode | (m_ddb << 3))) m_cnt = 0;
        if (d & 'h10) begin m_bcc = 0; m_cnt = 0; end
        m_mode = d & 7; m_ddb = (d >> 3) & 1; m_sen = (d >> 6) & 1;
        m_step = ((d >> 5) & 1) && !m_sen;
      end else if (a == 2) begin
        if (be & 1) m_dr = (m_dr & 'hFF00) | (d & 'hFF);
        if (be & 2) m_dr = (m_dr & 'h00FF) | (d & 'hFF00);
        m_done = 0; m_cnt = 0;
      end
    end else begin
      if (!m_done && m_cnt < n && (m_sen || m_step)) begin
        f = (m_bcc ^ m_dr) & 1;
        case (m_mode)
          0: begin v = (m_bcc & 'hFFF) >> 1; if (f) v = v ^ 'hF01; m_bcc = v; end
          1: begin m_bcc = m_bcc >> 1; if (f) m_bcc = m_bcc ^ 'hA001; end
          5: begin m_bcc = m_bcc >> 1; if (f) m_bcc = m_bcc ^ 'h8408; end
          2: m_bcc = (m_bcc & 'hFF00) | (f << 7) | ((m_bcc & 'hFF) >> 1);
          3: m_bcc = (f << 15) | (m_bcc >> 1);
          default: ;
        endcase
        m_dr = m_dr >> 1;
        m_quo = f;
        m_cnt = m_cnt + 1;
        if (m_cnt >= n) m_done = 1;
      end else if (!m_done && m_cnt >= n) begin
        m_done = 1;
      end
      m_step = 0;
    end
  endtask

  task automatic compare(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %04h expected %04h (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  // one clock: check outputs at negedge, then drive this cycle's bus op
  task automatic cyc(int we, int a, int be, int d);
    int exp_csr;
    @(negedge clk_i);
    we_i = 1'b0;
    addr_i = 2'd0; #1;
    exp_csr = m_mode | (m_ddb << 3) | (m_sen << 6) | (m_done << 7) | (m_quo << 8);
    compare("ctl/status", int'(rdata_o), exp_csr);
    addr_i = 2'd1; #1;
    compare("result", int'(rdata_o), view_result());
    addr_i = 2'd2; #1;
    compare("data readback", int'(rdata_o), 0);
    we_i = (we != 0); addr_i = 2'(a); be_i = 2'(be); wdata_i = 16'(d);
    @(posedge clk_i);
    model_step(we, a, be, d);
  endtask

  task automatic wr(int a, int be, int d); cyc(1, a, be, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    cur_req = "R1";  idle(2);
    cur_req = "R5";  wr(0, 1, 'h41); wr(2, 3, 'h00A5); idle(12);
    wr(0, 1, 'h49); wr(2, 3, 'hBEEF); idle(20);
    wr(0, 1, 'h55); wr(2, 3, 'h3132); idle(12);
    wr(0, 1, 'h5D); wr(2, 3, 'hC0DE); idle(20);
    cur_req = "R6";  wr(0, 1, 'h50); wr(2, 3, 'h002A); idle(9); wr(2, 3, 'h0015); idle(9);
    wr(0, 1, 'h48); wr(2, 3, 'h0ABC); idle(16);
    cur_req = "R7";  wr(0, 1, 'h52); wr(2, 3, 'h005A); idle(10); wr(2, 3, 'h00C3); idle(10);
    wr(0, 1, 'h5B); wr(2, 3, 'h1234); idle(18); wr(2, 3, 'hFFFF); idle(18);
    wr(0, 1, 'h43); wr(2, 3, 'h00F0); idle(10);
    cur_req = "R4";  wr(0, 1, 'h44); wr(2, 3, 'h0077); idle(4);
    wr(0, 1, 'h4E); wr(2, 3, 'h0011); idle(3); wr(0, 1, 'h47); wr(2, 3, 'h0001); idle(3);
    cur_req = "R9";  wr(0, 1, 'h11); wr(2, 3, 'h00F0); idle(3);
    for (int k = 0; k < 10; k++) begin wr(0, 1, 'h21); idle(2); end
    cur_req = "R13"; wr(0, 1, 'h15); wr(2, 3, 'h5A5A);
    for (int k = 0; k < 4; k++) begin wr(0, 1, 'h25); idle(1); end
    cur_req = "R2";  wr(0, 1, 'hFF); idle(3); wr(0, 1, 'h31); idle(2);
    cur_req = "R3";  wr(0, 1, 'h01); wr(2, 1, 'h00AA); wr(2, 2, 'h5500); idle(2);
    wr(0, 2, 'hFFFF); idle(2); wr(0, 1, 'h41); idle(10);
    wr(0, 1, 'h49); wr(2, 2, 'h8100); wr(2, 1, 'h7E7E); idle(18);
    cur_req = "R10"; wr(0, 1, 'h49); wr(2, 3, 'h1357); idle(3); wr(0, 1, 'h59); idle(20);
    wr(2, 3, 'h2468); idle(3); wr(0, 1, 'h41); idle(12);
    cur_req = "R12"; wr(1, 3, 'hFFFF); idle(2); wr(2, 3, 'h0F0F); idle(3); wr(1, 1, 'h00FF); idle(8);
    cur_req = "R8";  wr(0, 1, 'h01); wr(2, 3, 'h8001); idle(3); wr(0, 1, 'h41); idle(12);
    cur_req = "R11"; wr(2, 3, 'h3C3C); idle(25);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule